// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page mappings for a 32-bit address space with 4 KB pages. A requester presents a virtual address together with an access kind (read or write). All entries are searched at once, and one clock later the block reports a hit with a physical address, a miss, or a protection fault. The physical address is the cached physical page number placed above the page offset, which passes through unchanged.

A miss raises a stall flag that stays up until a miss handler delivers a refill or the buffer is flushed. The block picks the entry a refill goes into. It uses the lowest-numbered empty entry while one remains. Once the buffer is full, it uses a clock sweep that gives recently used entries a second chance. The chosen entry index is reported so the handler can see where the mapping landed. Each entry keeps read and write rights, a dirty flag for write-back paging and a use flag for replacement.

Top module: `xlate_buffer`

## Requirements
- R1: A lookup of a valid, permitted entry produces rsp_hit one cycle later, with rsp_paddr equal to the entry's 20-bit physical page number in bits 31:12 and the lookup address bits 11:0 in bits 11:0. The virtual page number is address bits 31:12.
- R2: Any virtual page may be placed in any of the 64 entries. While an empty entry exists, a refill goes into the lowest-numbered empty entry, and fill_slot reports that index from the cycle after the refill.
- R3: A lookup whose page matches no valid entry gives rsp_miss with rsp_paddr zero one cycle later and raises stall. stall remains high until a refill or flush cycle.
- R4: A read needs the entry's read right and a write needs its write right. Without the right, the result is rsp_fault with rsp_hit low, rsp_paddr zero and rsp_dirty low. The entry's dirty and use flags stay unchanged.
- R5: A permitted write hit sets the entry's dirty flag. On every hit, rsp_dirty reports the entry's dirty flag after the access. It is low on miss or fault.
- R6: A refill installs the valid flag, the tag, the physical page number and both rights, with the dirty and use flags cleared.
- R7: When all entries are valid, the refill victim is the first entry at or after the sweep pointer whose use flag is clear. The use flags of the entries passed over are cleared, and the pointer then moves to the entry after the victim. A permitted hit sets the use flag. The pointer is 0 after reset.
- R8: A flush invalidates every entry in one cycle. A refill presented in the same cycle as a flush is dropped.
- R9: After reset, all entries are invalid and rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_paddr, stall and fill_slot are all zero.
- R10: rsp_valid is high exactly in the cycle after lk_valid. With rsp_valid high, exactly one of rsp_hit, rsp_miss and rsp_fault is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| fill_en | input | 1 | Refill request this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rd | input | 1 | Read right of the new entry |
| fill_wr | input | 1 | Write right of the new entry |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Permitted hit |
| rsp_miss | output | 1 | No valid matching entry |
| rsp_fault | output | 1 | Matching entry lacks the needed right |
| rsp_dirty | output | 1 | Dirty flag of the hit entry after the access |
| rsp_paddr | output | 32 | Translated physical address |
| stall | output | 1 | Requester must wait for a refill |
| fill_slot | output | 6 | Entry index used by the latest refill |

## Verification
The properties assume that the requester never presents a refill in the same cycle as a lookup. They also assume that a page already cached is never refilled, so at most one entry can match any address. The bench issues refills only between lookups, while the requester is otherwise idle, and every refilled page is either new or was evicted before it returns. The stall property additionally assumes that a refill or flush does not coincide with a missing lookup, and the directed sequences keep these apart.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
  localparam int DEF_VA_W   = 32;
  localparam int DEF_PA_W   = 32;
  localparam int DEF_OFF_W  = 12;
  localparam int DEF_DEPTH  = 64;

  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_e;
endpackage

// File: rtl/xlb_match.sv
module xlb_match #(
  parameter int DEPTH = 64,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            ent_valid,
  input  logic [DEPTH-1:0][TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0]            key,
  output logic                        any_hit,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_tag[g] == key);
  end

  assign any_hit = |hit_vec;

  // at most one entry matches, so OR-ing indices encodes it
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlb_victim.sv
module xlb_victim #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] ent_valid,
  input  logic [DEPTH-1:0] ent_used,
  input  logic [IDX_W-1:0] sweep_ptr,
  output logic [IDX_W-1:0] victim,
  output logic [DEPTH-1:0] used_clr,
  output logic             sweep_move,
  output logic [IDX_W-1:0] sweep_nxt
);
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             clk_found;
  logic [IDX_W-1:0] clk_idx;
  logic [DEPTH-1:0] clk_clr;
  logic [IDX_W-1:0] pos;

  // lowest-numbered empty entry
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  // second-chance sweep starting at the pointer
  always_comb begin
    clk_found = 1'b0;
    clk_idx   = sweep_ptr;
    clk_clr   = '0;
    pos       = sweep_ptr;
    for (int d = 0; d < DEPTH; d++) begin
      pos = sweep_ptr + IDX_W'(d);
      if (!clk_found) begin
        if (!ent_used[pos]) begin
          clk_found = 1'b1;
          clk_idx   = pos;
        end else begin
          clk_clr[pos] = 1'b1;
        end
      end
    end
  end

  assign victim     = free_found ? free_idx : clk_idx;
  assign used_clr   = free_found ? '0 : clk_clr;
  assign sweep_move = !free_found;
  assign sweep_nxt  = clk_idx + IDX_W'(1);
endmodule

// File: rtl/xlate_buffer.sv
module xlate_buffer
  import xlb_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int VA_W  = DEF_VA_W,
  parameter int PA_W  = DEF_PA_W,
  parameter int OFF_W = DEF_OFF_W,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic             rsp_dirty,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             stall,
  output logic [IDX_W-1:0] fill_slot
);
  // entry state
  logic [DEPTH-1:0]            valid_q, dirty_q, used_q, rd_q, wr_q;
  logic [DEPTH-1:0][VPN_W-1:0] tag_q;
  logic [DEPTH-1:0][PPN_W-1:0] ppn_q;
  logic [IDX_W-1:0]            sweep_q;

  logic [DEPTH-1:0] valid_nx, dirty_nx, used_nx;

  // lookup path
  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;
  acc_e             acc;
  logic             right_ok;
  logic             look_ok, look_fault, look_miss;

  // refill path
  logic             fill_go;
  logic [IDX_W-1:0] victim;
  logic [DEPTH-1:0] used_clr;
  logic             sweep_move;
  logic [IDX_W-1:0] sweep_nxt;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];
  assign acc    = acc_e'(lk_write);

  xlb_match #(.DEPTH(DEPTH), .TAG_W(VPN_W)) u_match (
    .ent_valid (valid_q),
    .ent_tag   (tag_q),
    .key       (lk_vpn),
    .any_hit   (any_hit),
    .hit_idx   (hit_idx)
  );

  xlb_victim #(.DEPTH(DEPTH)) u_victim (
    .ent_valid  (valid_q),
    .ent_used   (used_q),
    .sweep_ptr  (sweep_q),
    .victim     (victim),
    .used_clr   (used_clr),
    .sweep_move (sweep_move),
    .sweep_nxt  (sweep_nxt)
  );

  assign right_ok   = (acc == ACC_WR) ? wr_q[hit_idx] : rd_q[hit_idx];
  assign look_ok    = lk_valid && any_hit && right_ok;
  assign look_fault = lk_valid && any_hit && !right_ok;
  assign look_miss  = lk_valid && !any_hit;
  assign fill_go    = fill_en && !flush;

  // next state of the per-entry flag vectors
  always_comb begin
    valid_nx = valid_q;
    dirty_nx = dirty_q;
    used_nx  = used_q;
    if (look_ok) begin
      used_nx[hit_idx] = 1'b1;
      if (acc == ACC_WR) dirty_nx[hit_idx] = 1'b1;
    end
    if (fill_go) begin
      used_nx          = used_nx & ~used_clr;
      used_nx[victim]  = 1'b0;
      dirty_nx[victim] = 1'b0;
      valid_nx[victim] = 1'b1;
    end
    if (flush) valid_nx = '0;
  end

  // flag vectors and response registers
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      dirty_q   <= '0;
      used_q    <= '0;
      sweep_q   <= '0;
      fill_slot <= '0;
      stall     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      valid_q   <= valid_nx;
      dirty_q   <= dirty_nx;
      used_q    <= used_nx;
      rsp_valid <= lk_valid;
      rsp_hit   <= look_ok;
      rsp_miss  <= look_miss;
      rsp_fault <= look_fault;
      rsp_dirty <= look_ok && (dirty_q[hit_idx] || (acc == ACC_WR));
      rsp_paddr <= look_ok ? {ppn_q[hit_idx], lk_off} : '0;
      if (flush || fill_en) stall <= 1'b0;
      else if (look_miss)   stall <= 1'b1;
      if (fill_go) begin
        fill_slot <= victim;
        if (sweep_move) sweep_q <= sweep_nxt;
      end
    end
  end

  // payload storage: written only on refill, no reset needed
  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[victim] <= fill_vpn;
      ppn_q[victim] <= fill_ppn;
      rd_q[victim]  <= fill_rd;
      wr_q[victim]  <= fill_wr;
    end
  end
endmodule

// File: rtl/xlate_buffer_chk.sv
module xlate_buffer_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_write,
  input logic            fill_en,
  input logic            flush,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic            rsp_dirty,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            stall
);
  a_r10_resp_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> rsp_paddr == '0);

  a_r3_stall_raised: assert property (@(posedge clk) disable iff (rst)
    lk_valid && !fill_en && !flush |=> (!rsp_miss || stall));

  a_r4_fault_clean: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (!rsp_dirty && rsp_paddr == '0));

  a_r5_write_dirty: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_write |=> (!rsp_hit || rsp_dirty));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush ##1 lk_valid |=> !rsp_hit);
endmodule

bind xlate_buffer xlate_buffer_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_vaddr  (lk_vaddr),
  .lk_write  (lk_write),
  .fill_en   (fill_en),
  .flush     (flush),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_fault (rsp_fault),
  .rsp_dirty (rsp_dirty),
  .rsp_paddr (rsp_paddr),
  .stall     (stall)
);

// File: tb/xlate_buffer_tb.sv
module xlate_buffer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_rd = 1'b0;
  logic        fill_wr = 1'b0;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, stall;
  logic [31:0] rsp_paddr;
  logic [5:0]  fill_slot;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xlate_buffer u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rd(fill_rd),
    .fill_wr(fill_wr), .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty),
    .rsp_paddr(rsp_paddr), .stall(stall), .fill_slot(fill_slot)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        hit;
    logic        miss;
    logic        fault;
    logic        dirty;
    logic [31:0] pa;
  } vec_t;

  // entries: 0x12345->0xABCDE rw, 0x00001->0x00777 read only, 0xFFFFF->0x00042 write only
  localparam vec_t VEC [9] = '{
    '{32'h12345678, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hABCDE678},
    '{32'h12345FFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'hABCDEFFF},
    '{32'h12345000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'hABCDE000},
    '{32'h00001ABC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00777ABC},
    '{32'h00001ABC, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000},
    '{32'h00001ABC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00777ABC},
    '{32'hFFFFF001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000},
    '{32'hFFFFF001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00042001},
    '{32'h55555000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] a, input logic w);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = a; lk_write = w;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic refill(input logic [19:0] v, input logic [19:0] p, input logic r, input logic w);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_rd = r; fill_wr = w;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic resp(input string tag, input logic h, input logic m, input logic f,
                      input logic d, input logic [31:0] pa);
    chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " outcome"}, {29'd0, rsp_hit, rsp_miss, rsp_fault}, {29'd0, h, m, f});
    chk({tag, " dirty"}, {31'd0, rsp_dirty}, {31'd0, d});
    chk({tag, " paddr"}, rsp_paddr, pa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, stall}, 32'd0);
    chk("R9 paddr", rsp_paddr, 32'd0);
    chk("R9 slot", {26'd0, fill_slot}, 32'd0);
    @(negedge clk);
    chk("R10 idle no response", {31'd0, rsp_valid}, 32'd0);
    lookup(32'h12345678, 1'b0);
    resp("R9 empty after reset", 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    chk("R3 stall on miss", {31'd0, stall}, 32'd1);

    // R2 R6 first-free placement
    refill(20'h12345, 20'hABCDE, 1'b1, 1'b1);
    chk("R3 stall cleared by refill", {31'd0, stall}, 32'd0);
    chk("R2 slot 0", {26'd0, fill_slot}, 32'd0);
    refill(20'h00001, 20'h00777, 1'b1, 1'b0);
    chk("R2 slot 1", {26'd0, fill_slot}, 32'd1);
    refill(20'hFFFFF, 20'h00042, 1'b0, 1'b1);
    chk("R2 slot 2", {26'd0, fill_slot}, 32'd2);

    // table: R1 R4 R5 R3
    for (int i = 0; i < 9; i++) begin
      lookup(VEC[i].addr, VEC[i].wr);
      resp($sformatf("R1/R4/R5 vector %0d", i), VEC[i].hit, VEC[i].miss, VEC[i].fault,
           VEC[i].dirty, VEC[i].pa);
    end
    chk("R3 stall held after miss", {31'd0, stall}, 32'd1);
    @(negedge clk);
    chk("R3 stall still held", {31'd0, stall}, 32'd1);
    refill(20'h55555, 20'h0BEEF, 1'b1, 1'b1);
    chk("R3 stall released", {31'd0, stall}, 32'd0);
    chk("R2 slot 3", {26'd0, fill_slot}, 32'd3);
    lookup(32'h55555123, 1'b0);
    resp("R2 new entry hit", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0BEEF123);

    // R8 flush empties, and wins over a same-cycle refill
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h07777; fill_ppn = 20'h01111;
    fill_rd = 1'b1; fill_wr = 1'b1;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    chk("R8 slot unchanged by dropped refill", {26'd0, fill_slot}, 32'd3);
    lookup(32'h12345678, 1'b0);
    resp("R8 flushed entry misses", 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    lookup(32'h07777000, 1'b0);
    resp("R8 dropped refill misses", 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);

    // fill all 64 entries
    for (int i = 0; i < 64; i++) begin
      refill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b1, 1'b1);
      chk($sformatf("R2 fill slot %0d", i), {26'd0, fill_slot}, i);
    end
    lookup(32'h00100ABC, 1'b0);
    resp("R6 refilled entry clean", 1'b1, 1'b0, 1'b0, 1'b0, 32'h00200ABC);
    lookup(32'h00101000, 1'b0);
    resp("R7 use slot 1", 1'b1, 1'b0, 1'b0, 1'b0, 32'h00201000);
    lookup(32'h00102000, 1'b0);
    resp("R7 use slot 2", 1'b1, 1'b0, 1'b0, 1'b0, 32'h00202000);

    // R7 sweep from pointer 0 skips used slots 0..2
    refill(20'h00300, 20'h00333, 1'b1, 1'b1);
    chk("R7 victim skips used", {26'd0, fill_slot}, 32'd3);
    lookup(32'h00103000, 1'b0);
    resp("R7 evicted page misses", 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    lookup(32'h00300ABC, 1'b0);
    resp("R7 replacement hits", 1'b1, 1'b0, 1'b0, 1'b0, 32'h00333ABC);
    refill(20'h00301, 20'h00334, 1'b1, 1'b1);
    chk("R7 pointer advanced", {26'd0, fill_slot}, 32'd4);
    lookup(32'h00100004, 1'b0);
    resp("R7 second-chance entry kept", 1'b1, 1'b0, 1'b0, 1'b0, 32'h00200004);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule